// File: doc/BRIEF.md
# Packed Byte Add/Subtract with Flag-Steered Select

This unit treats each 32-bit operand as four independent byte lanes. On an arithmetic operation it adds or subtracts the lanes in parallel, in either unsigned or two's-complement mode. It registers the four wrapped 8-bit results as one packed word. Alongside the result, every lane records one greater-or-equal flag in a 4-bit flag register.

A second operation, select, assembles a word byte by byte from its two source operands. The stored flags steer the choice. Issuing a compare-style subtraction followed by a select therefore gives a per-byte choice without branches, for example a byte-wise maximum or minimum.

Every operation is registered. Results and flags become visible on the outputs in the cycle after the clock edge that accepts the operation.

Top module: `pbyte_unit`

## Requirements
- R1: With opcode 3'b000 (unsigned add) and write enable high, each result byte is (A+B) mod 256 of its lane, and that lane's flag becomes the carry out of the 8-bit addition.
- R2: With opcode 3'b001 (unsigned subtract) and write enable high, each result byte is (A-B) mod 256, and the flag is 1 exactly when the unsigned A byte is at least the B byte (no borrow).
- R3: With opcode 3'b010 (signed add) and write enable high, each result byte is the wrapped sum, and the flag is 1 exactly when the exact 9-bit signed sum of the two bytes is zero or positive.
- R4: With opcode 3'b011 (signed subtract) and write enable high, each result byte is the wrapped difference, and the flag is 1 exactly when A is at least B as two's-complement bytes.
- R5: With opcode 3'b100 (select) and write enable high, result byte i (bits 8i+7..8i) is taken from operand A when stored flag bit i is 1, and from operand B when it is 0.
- R6: A select operation leaves the flag register unchanged.
- R7: While write enable is low, both the result and the flags hold their values, whatever the opcode and operands.
- R8: Opcodes 3'b101, 3'b110 and 3'b111 change neither the result nor the flags, even with write enable high.
- R9: After reset, the result reads 0 and the flags read 4'b0000.
- R10: Result and flags appear one cycle after the accepting edge, and a select issued in the very next cycle is steered by the flags that the preceding arithmetic operation just wrote.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| opA | input | 32 | First operand, or the source chosen on flag = 1 |
| opB | input | 32 | Second operand, or the source chosen on flag = 0 |
| opCode | input | 3 | Operation code (see R1–R5, R8) |
| wrEn | input | 1 | Accept the operation on this edge |
| result | output | 32 | Registered packed result |
| geFlags | output | 4 | Registered per-lane greater-or-equal flags, bit i for byte lane i |

## Verification
Flag production and flag consumption meet at a single edge. An arithmetic operation writes the flag register at the same edge at which a select issued in the next cycle samples its operands. The following cycle then computes the select from the register. The bench issues arithmetic and select back to back, with no idle cycle between them. A scoreboard model predicts each select from the flags of the preceding operation and compares the bytes of the select result against that prediction. Random streams that mix in selects, holds and reserved codes probe the same boundary from many flag patterns.

// File: rtl/pbyte_pkg.sv
`timescale 1ns/1ps
package pbyte_pkg;

  typedef enum logic [2:0] {
    OP_UADD = 3'd0,
    OP_USUB = 3'd1,
    OP_SADD = 3'd2,
    OP_SSUB = 3'd3,
    OP_SEL  = 3'd4
  } pbyteOp_e;

  // Strobes from the decoder to the datapath
  typedef struct packed {
    logic loadResult;
    logic loadFlags;
    logic doSub;
    logic signedMode;
    logic pickSel;
  } pbyteStb_t;

endpackage

// File: rtl/pbyte_lane.sv
`timescale 1ns/1ps
// One byte lane: widened add/subtract, wrapped result and ge flag.
module pbyte_lane #(
  parameter int LANE_W = 8
) (
  input  logic [LANE_W-1:0] aIn,
  input  logic [LANE_W-1:0] bIn,
  input  logic              doSub,
  input  logic              signedMode,
  output logic [LANE_W-1:0] sumOut,
  output logic              geOut
);
  localparam int EXT_W = LANE_W + 1;

  logic [EXT_W-1:0] extA;
  logic [EXT_W-1:0] extB;
  logic [EXT_W-1:0] wideSum;

  // Extra bit is a sign copy in signed mode, zero otherwise
  assign extA = {signedMode & aIn[LANE_W-1], aIn};
  assign extB = {signedMode & bIn[LANE_W-1], bIn};

  always_comb begin
    if (doSub) wideSum = extA - extB;
    else       wideSum = extA + extB;
  end

  assign sumOut = wideSum[LANE_W-1:0];

  // Unsigned add: top bit is the carry. Every other mode: top bit set
  // means a borrow or a negative exact result, so invert it.
  assign geOut = (doSub | signedMode) ? ~wideSum[LANE_W] : wideSum[LANE_W];

endmodule

// File: rtl/pbyte_ctrl.sv
`timescale 1ns/1ps
// Opcode decode into datapath strobes.
module pbyte_ctrl import pbyte_pkg::*; (
  input  logic [2:0] opCode,
  input  logic       wrEn,
  output pbyteStb_t  stb
);
  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (opCode)
        OP_UADD: begin
          stb.loadResult = 1'b1;
          stb.loadFlags  = 1'b1;
        end
        OP_USUB: begin
          stb.loadResult = 1'b1;
          stb.loadFlags  = 1'b1;
          stb.doSub      = 1'b1;
        end
        OP_SADD: begin
          stb.loadResult = 1'b1;
          stb.loadFlags  = 1'b1;
          stb.signedMode = 1'b1;
        end
        OP_SSUB: begin
          stb.loadResult = 1'b1;
          stb.loadFlags  = 1'b1;
          stb.doSub      = 1'b1;
          stb.signedMode = 1'b1;
        end
        OP_SEL: begin
          stb.loadResult = 1'b1;
          stb.pickSel    = 1'b1;
        end
        default: stb = '0;
      endcase
    end
  end
endmodule

// File: rtl/pbyte_datapath.sv
`timescale 1ns/1ps
// Lanes, select mux, result and flag registers.
module pbyte_datapath import pbyte_pkg::*; #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  input  pbyteStb_t               stb,
  output logic [LANES*LANE_W-1:0] result,
  output logic [LANES-1:0]        flags
);
  localparam int WORD_W = LANES * LANE_W;
  localparam int LANE_MAX = (1 << LANE_W) - 1;

  logic [WORD_W-1:0] laneSum;
  logic [WORD_W-1:0] selWord;
  logic [WORD_W-1:0] nextResult;
  logic [LANES-1:0]  laneGe;
  logic [WORD_W-1:0] resultQ;
  logic [LANES-1:0]  flagQ;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    pbyte_lane #(.LANE_W(LANE_W)) u_lane (
      .aIn        (opA[g*LANE_W +: LANE_W]),
      .bIn        (opB[g*LANE_W +: LANE_W]),
      .doSub      (stb.doSub),
      .signedMode (stb.signedMode),
      .sumOut     (laneSum[g*LANE_W +: LANE_W]),
      .geOut      (laneGe[g])
    );

    assign selWord[g*LANE_W +: LANE_W] =
      flagQ[g] ? opA[g*LANE_W +: LANE_W] : opB[g*LANE_W +: LANE_W];

    // R1: unsigned add flag is the lane carry
    p_uadd_carry_r1: assert property (@(posedge clk) disable iff (!rstN)
      (stb.loadFlags && !stb.doSub && !stb.signedMode) |=>
        flagQ[g] == ((32'($past(opA[g*LANE_W +: LANE_W])) +
                      32'($past(opB[g*LANE_W +: LANE_W]))) > LANE_MAX));

    // R2: unsigned subtract flag is the no-borrow indication
    p_usub_noborrow_r2: assert property (@(posedge clk) disable iff (!rstN)
      (stb.loadFlags && stb.doSub && !stb.signedMode) |=>
        flagQ[g] == ($past(opA[g*LANE_W +: LANE_W]) >= $past(opB[g*LANE_W +: LANE_W])));

    // R4: signed subtract flag is the signed comparison
    p_ssub_ge_r4: assert property (@(posedge clk) disable iff (!rstN)
      (stb.loadFlags && stb.doSub && stb.signedMode) |=>
        flagQ[g] == ($signed($past(opA[g*LANE_W +: LANE_W])) >=
                     $signed($past(opB[g*LANE_W +: LANE_W]))));
  end

  assign nextResult = stb.pickSel ? selWord : laneSum;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resultQ <= '0;
      flagQ   <= '0;
    end else begin
      if (stb.loadResult) resultQ <= nextResult;
      if (stb.loadFlags)  flagQ   <= laneGe;
    end
  end

  assign result = resultQ;
  assign flags  = flagQ;

endmodule

// File: rtl/pbyte_unit.sv
`timescale 1ns/1ps
// Packed byte add/subtract with flag-steered select: thin top.
module pbyte_unit import pbyte_pkg::*; #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [LANES*LANE_W-1:0] opA,
  input  logic [LANES*LANE_W-1:0] opB,
  input  logic [2:0]              opCode,
  input  logic                    wrEn,
  output logic [LANES*LANE_W-1:0] result,
  output logic [LANES-1:0]        geFlags
);
  localparam int WORD_W = LANES * LANE_W;

  pbyteStb_t stb;

  pbyte_ctrl u_ctrl (
    .opCode (opCode),
    .wrEn   (wrEn),
    .stb    (stb)
  );

  pbyte_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .opB    (opB),
    .stb    (stb),
    .result (result),
    .flags  (geFlags)
  );

  function automatic logic [WORD_W-1:0] pickBytes(
    input logic [WORD_W-1:0] a,
    input logic [WORD_W-1:0] b,
    input logic [LANES-1:0]  f
  );
    logic [WORD_W-1:0] w;
    for (int i = 0; i < LANES; i++)
      w[i*LANE_W +: LANE_W] = f[i] ? a[i*LANE_W +: LANE_W] : b[i*LANE_W +: LANE_W];
    return w;
  endfunction

  p_hold_when_idle_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |=> ($stable(result) && $stable(geFlags)));

  p_sel_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opCode == OP_SEL) |=> $stable(geFlags));

  p_sel_bytes_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opCode == OP_SEL) |=>
      result == pickBytes($past(opA), $past(opB), $past(geFlags)));

  p_reserved_inert_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && opCode > OP_SEL) |=> ($stable(result) && $stable(geFlags)));

endmodule

// File: tb/pbyte_unit_bench.sv
`timescale 1ns/1ps
module pbyte_unit_bench;

  localparam real HALF = 4.0;   // 125 MHz

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic [2:0]  opCode = '0;
  logic        wrEn = 1'b0;
  logic [31:0] result;
  logic [3:0]  geFlags;

  always #(HALF) clk = ~clk;

  pbyte_unit u_pbyte_unit (
    .clk(clk), .rstN(rstN), .opA(opA), .opB(opB),
    .opCode(opCode), .wrEn(wrEn), .result(result), .geFlags(geFlags)
  );

  typedef struct {
    logic [31:0] res;
    logic [3:0]  fl;
    string       tag;
  } item_t;

  item_t       expQ[$];
  int          checks = 0;
  int          fails = 0;
  logic [31:0] modelRes = '0;
  logic [3:0]  modelFl = '0;

  // Driver: drive on the falling edge, push the expected outcome
  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [2:0] op, input logic we, input string tag);
    item_t it;
    logic [31:0] nr;
    logic [3:0]  nf;
    @(negedge clk);
    opA = a; opB = b; opCode = op; wrEn = we;
    nr = modelRes;
    nf = modelFl;
    if (we && op <= 3'd4) begin
      for (int i = 0; i < 4; i++) begin
        int ua, ub, sa, sb, r;
        ua = int'(a[i*8 +: 8]);
        ub = int'(b[i*8 +: 8]);
        sa = (ua > 127) ? ua - 256 : ua;
        sb = (ub > 127) ? ub - 256 : ub;
        case (op)
          3'd0: begin r = ua + ub; nf[i] = (r > 255); end
          3'd1: begin r = ua - ub; nf[i] = (ua >= ub); end
          3'd2: begin r = sa + sb; nf[i] = (r >= 0); end
          3'd3: begin r = sa - sb; nf[i] = (sa >= sb); end
          default: r = modelFl[i] ? ua : ub;
        endcase
        nr[i*8 +: 8] = r[7:0];
      end
    end
    modelRes = nr;
    modelFl  = nf;
    it.res = nr; it.fl = nf; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: results are visible shortly after the accepting edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expQ.size() > 0) begin
        item_t e;
        e = expQ.pop_front();
        checks++;
        if (result !== e.res || geFlags !== e.fl) begin
          fails++;
          $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                   e.tag, result, geFlags, e.res, e.fl);
        end
      end
    end
  end

  initial begin
    #(HALF * 2.0 * 200000.0);
    fails++;
    checks++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  string tagFor[8] = '{"R1", "R2", "R3", "R4", "R5", "R8", "R8", "R8"};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checks++;   // R9: reset state
    if (result !== 32'h0 || geFlags !== 4'b0000) begin
      fails++;
      $display("FAIL R9: result=%h flags=%b expected result=%h flags=%b",
               result, geFlags, 32'h0, 4'b0000);
    end

    // R5 with reset flags: every byte comes from B
    issue(32'h1111_1111, 32'h2222_2222, 3'd4, 1'b1, "R5");
    // R1 carries into every lane pattern, then select at once (R10)
    issue(32'hFF80_0102, 32'h0180_FF01, 3'd0, 1'b1, "R1");
    issue(32'hAAAA_AAAA, 32'h5555_5555, 3'd4, 1'b1, "R10");
    // R2 boundary: equal lanes, one below, one above
    issue(32'h4000_7F10, 32'h4001_7F0F, 3'd1, 1'b1, "R2");
    issue(32'hA1B2_C3D4, 32'h0102_0304, 3'd4, 1'b1, "R10");
    issue(32'h0000_0000, 32'hFFFF_FFFF, 3'd4, 1'b1, "R6");
    // R3 extremes: -128+-128, 127+127, 0+0, -1+1
    issue(32'h807F_00FF, 32'h807F_0001, 3'd2, 1'b1, "R3");
    issue(32'h1234_5678, 32'h9ABC_DEF0, 3'd4, 1'b1, "R10");
    // R4: -128 vs 127, 127 vs -128, equal, -1 vs 0
    issue(32'h807F_55FF, 32'h7F80_5500, 3'd3, 1'b1, "R4");
    issue(32'hCAFE_BABE, 32'h0BAD_F00D, 3'd4, 1'b1, "R10");
    // R7: write enable low, any opcode
    issue(32'hFFFF_FFFF, 32'h0101_0101, 3'd0, 1'b0, "R7");
    issue(32'h1234_5678, 32'h8765_4321, 3'd4, 1'b0, "R7");
    // R8: reserved opcodes with write enable high
    issue(32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'd5, 1'b1, "R8");
    issue(32'h0000_0000, 32'hFFFF_FFFF, 3'd6, 1'b1, "R8");
    issue(32'h7F7F_7F7F, 32'h8080_8080, 3'd7, 1'b1, "R8");

    // Mixed random stream
    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      logic       we;
      op = 3'($urandom_range(0, 7));
      we = ($urandom_range(0, 7) != 0);
      issue($urandom, $urandom, op, we, we ? tagFor[op] : "R7");
    end

    issue(32'h0, 32'h0, 3'd0, 1'b0, "R7");
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule